// File: doc/BRIEF.md
# Two-Sided Inter-Processor Mailbox

This block joins two processors, side A and side B, that share one clock. Each side reaches the block through its own 32-bit register port and gets its own interrupt line. There are four one-word message channels in each direction. When a side writes one of its four send registers, the word appears in the matching receive register on the other side. The sender sees its channel as busy until the receiver reads the word out. Each side also has four doorbells that ring at the other side and three flag bits that the other side can read.

Every event that one side raises shows up in the other side's status register. Each status event bit has an enable at the same bit position in the control register. A side's interrupt line is high while any enabled event is present. Software can work by interrupt or by polling the status register.

Top module: `msgu_top`

## Requirements
- R1: After reset both control registers read 0x00000000, both status registers read 0x00F00000 (every send channel empty, nothing else set), and both interrupt lines are low.
- R2: Word offsets 0x00, 0x04, 0x08 and 0x0C are the send registers for channels 0 to 3. Offsets 0x10 to 0x1C are the matching receive registers. Writing send register n clears status bit 23−n (send-empty) on the writer and sets status bit 27−n (receive-full) on the other side. The other side's receive register n then returns the written word.
- R3: Reading receive register n clears the reader's status bit 27−n and sets status bit 23−n again on the sending side.
- R4: Writing a send register again before the word has been read replaces the word. The receiver then reads only the newest word, and a single read empties the channel.
- R5: Writing 1 to control bit 19−n (doorbell request n) sets status bit 31−n (doorbell pending) on the other side. The request bit reads back as 1 only on the cycle right after the write. It reads 0 once the request has been delivered.
- R6: Writing 1 to status bit 31−n clears doorbell pending n. Writing 0 there, or writing any other status bit, changes nothing.
- R7: A doorbell request that arrives while the pending bit is already set merges with it. One clear then leaves the pending bit at 0.
- R8: Control bits 31−n, 27−n and 23−n enable the doorbell, receive-full and send-empty events of channel n. The interrupt line of a side is high exactly while some status event bit and its enable are both 1.
- R9: Control bits 2:0 of a side show up at status bits 18:16 of the other side. Writes to the status register cannot change them.
- R10: A read returns its data on the clock edge that samples the read strobe. Status bits 15:0 and 19, reads of send registers, and reads of unused offsets all return 0.
- R11: The two sides behave the same way: every mapping above also holds from side B to side A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| a_addr | input | 6 | Side A byte address |
| a_we | input | 1 | Side A write strobe |
| a_wdata | input | 32 | Side A write data |
| a_re | input | 1 | Side A read strobe |
| a_rdata | output | 32 | Side A read data, registered |
| a_irq | output | 1 | Side A interrupt |
| b_addr | input | 6 | Side B byte address |
| b_we | input | 1 | Side B write strobe |
| b_wdata | input | 32 | Side B write data |
| b_re | input | 1 | Side B read strobe |
| b_rdata | output | 32 | Side B read data, registered |
| b_irq | output | 1 | Side B interrupt |

## Verification
The assertions check on every cycle that a channel write fills the channel, that a read with no write drains it, and that a stored word never changes without a write. They also check that a doorbell request always turns into a pending bit and then drops, that a pending bit never falls unless it was cleared, that the control register holds between writes, and that no interrupt rises while every enable is off. Only the bench scenarios can show the register map and the reversed channel ordering, the merging of repeated doorbells, the flag mirroring, the interrupt masking combinations and the mirror-image behaviour of side B. Each of these is observed through reads of the registers and the interrupt pins.

// File: rtl/msgu_pkg.sv
package msgu_pkg;

    parameter int unsigned NCH   = 4;
    parameter int unsigned DW    = 32;
    parameter int unsigned NFLAG = 3;
    parameter int unsigned AW    = 6;

    localparam int unsigned IW = $clog2(NCH);
    localparam int unsigned WW = AW - 2;

    // bit group bases; channel n sits at base + NCH-1-n
    localparam int unsigned GP_BASE   = 28;
    localparam int unsigned RF_BASE   = 24;
    localparam int unsigned TE_BASE   = 20;
    localparam int unsigned REQ_BASE  = 16;
    localparam int unsigned FLG_ST_LO = 16;
    localparam int unsigned FLG_CT_LO = 0;

    typedef enum logic [2:0] {
        K_SEND = 3'd0,
        K_RECV = 3'd1,
        K_STAT = 3'd2,
        K_CTRL = 3'd3,
        K_NONE = 3'd4
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e       kind;
        logic [IW-1:0]   idx;
    } dec_t;

    typedef struct packed {
        logic [NCH-1:0]   gie;
        logic [NCH-1:0]   rie;
        logic [NCH-1:0]   tie;
        logic [NFLAG-1:0] flags;
    } ctrl_t;

    function automatic int unsigned lane_bit(int unsigned base, int unsigned n);
        return base + NCH - 1 - n;
    endfunction

    function automatic dec_t decode_addr(logic [AW-1:0] a);
        dec_t          d;
        logic [WW-1:0] w;
        w     = a[AW-1:2];
        d.idx = w[IW-1:0];
        if (w < WW'(NCH))               d.kind = K_SEND;
        else if (w < WW'(2*NCH))        d.kind = K_RECV;
        else if (w == WW'(2*NCH))       d.kind = K_STAT;
        else if (w == WW'(2*NCH + 1))   d.kind = K_CTRL;
        else                            d.kind = K_NONE;
        return d;
    endfunction

endpackage

// File: rtl/msgu_lane.sv
module msgu_lane #(
    parameter int unsigned DW = msgu_pkg::DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic          full,
    output logic [DW-1:0] word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            word <= '0;
        end else if (wr_en) begin
            full <= 1'b1;
            word <= wr_data;
        end else if (rd_en) begin
            full <= 1'b0;
        end
    end

    assert_fill_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> full);

    assert_drain_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en) |=> !full);

    assert_word_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(word));

endmodule

// File: rtl/msgu_doorbell.sv
module msgu_doorbell (
    input  logic clk,
    input  logic rst,
    input  logic req_set,
    input  logic pend_clr,
    output logic req,
    output logic pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req  <= 1'b0;
            pend <= 1'b0;
        end else begin
            req <= req_set;
            if (req)
                pend <= 1'b1;
            else if (pend_clr)
                pend <= 1'b0;
        end
    end

    assert_deliver_R5: assert property (@(posedge clk) disable iff (rst)
        req |=> pend);

    assert_req_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (req && !req_set) |=> !req);

    assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (pend && !pend_clr) |=> pend);

endmodule

// File: rtl/msgu_port.sv
module msgu_port
    import msgu_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [AW-1:0]           addr,
    input  logic                    we,
    input  logic [DW-1:0]           wdata,
    input  logic                    re,
    output logic [DW-1:0]           rdata,
    output logic                    irq,
    output logic [NCH-1:0]          tx_wr,
    output logic [DW-1:0]           tx_data,
    input  logic [NCH-1:0]          tx_busy,
    input  logic [NCH-1:0]          rx_full,
    input  logic [NCH-1:0][DW-1:0]  rx_word,
    output logic [NCH-1:0]          rx_rd,
    output logic [NCH-1:0]          gp_set,
    input  logic [NCH-1:0]          gp_req,
    input  logic [NCH-1:0]          gp_pend,
    output logic [NCH-1:0]          gp_clr,
    output logic [NFLAG-1:0]        flags_out,
    input  logic [NFLAG-1:0]        flags_in
);

    dec_t          dec;
    logic          ctrl_wr;
    logic          stat_wr;
    ctrl_t         ctrl_q;
    logic [DW-1:0] stat_view;
    logic [DW-1:0] ctrl_view;

    assign dec     = decode_addr(addr);
    assign ctrl_wr = we && (dec.kind == K_CTRL);
    assign stat_wr = we && (dec.kind == K_STAT);
    assign tx_data = wdata;

    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            tx_wr[n]  = we && (dec.kind == K_SEND) && (dec.idx == IW'(n));
            rx_rd[n]  = re && (dec.kind == K_RECV) && (dec.idx == IW'(n));
            gp_set[n] = ctrl_wr && wdata[lane_bit(REQ_BASE, n)];
            gp_clr[n] = stat_wr && wdata[lane_bit(GP_BASE, n)];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            for (int n = 0; n < NCH; n++) begin
                ctrl_q.gie[n] <= wdata[lane_bit(GP_BASE, n)];
                ctrl_q.rie[n] <= wdata[lane_bit(RF_BASE, n)];
                ctrl_q.tie[n] <= wdata[lane_bit(TE_BASE, n)];
            end
            ctrl_q.flags <= wdata[FLG_CT_LO +: NFLAG];
        end
    end

    assign flags_out = ctrl_q.flags;

    always_comb begin
        stat_view = '0;
        ctrl_view = '0;
        for (int n = 0; n < NCH; n++) begin
            stat_view[lane_bit(GP_BASE, n)]  = gp_pend[n];
            stat_view[lane_bit(RF_BASE, n)]  = rx_full[n];
            stat_view[lane_bit(TE_BASE, n)]  = ~tx_busy[n];
            ctrl_view[lane_bit(GP_BASE, n)]  = ctrl_q.gie[n];
            ctrl_view[lane_bit(RF_BASE, n)]  = ctrl_q.rie[n];
            ctrl_view[lane_bit(TE_BASE, n)]  = ctrl_q.tie[n];
            ctrl_view[lane_bit(REQ_BASE, n)] = gp_req[n];
        end
        stat_view[FLG_ST_LO +: NFLAG] = flags_in;
        ctrl_view[FLG_CT_LO +: NFLAG] = ctrl_q.flags;
    end

    assign irq = |(gp_pend & ctrl_q.gie) | |(rx_full & ctrl_q.rie) | |(~tx_busy & ctrl_q.tie);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            case (dec.kind)
                K_RECV:  rdata <= rx_word[dec.idx];
                K_STAT:  rdata <= stat_view;
                K_CTRL:  rdata <= ctrl_view;
                default: rdata <= '0;
            endcase
        end
    end

    assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(ctrl_q));

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.gie == '0 && ctrl_q.rie == '0 && ctrl_q.tie == '0) |-> !irq);

endmodule

// File: rtl/msgu_top.sv
module msgu_top
    import msgu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] a_addr,
    input  logic          a_we,
    input  logic [DW-1:0] a_wdata,
    input  logic          a_re,
    output logic [DW-1:0] a_rdata,
    output logic          a_irq,
    input  logic [AW-1:0] b_addr,
    input  logic          b_we,
    input  logic [DW-1:0] b_wdata,
    input  logic          b_re,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq
);

    localparam int unsigned NSIDE = 2;

    logic [NSIDE-1:0][AW-1:0]          s_addr;
    logic [NSIDE-1:0]                  s_we;
    logic [NSIDE-1:0][DW-1:0]          s_wdata;
    logic [NSIDE-1:0]                  s_re;
    logic [NSIDE-1:0][DW-1:0]          s_rdata;
    logic [NSIDE-1:0]                  s_irq;

    logic [NSIDE-1:0][NCH-1:0]         tx_wr;
    logic [NSIDE-1:0][DW-1:0]          tx_data;
    logic [NSIDE-1:0][NCH-1:0]         rx_rd;
    logic [NSIDE-1:0][NCH-1:0]         lane_full;   // indexed by sending side
    logic [NSIDE-1:0][NCH-1:0][DW-1:0] lane_word;
    logic [NSIDE-1:0][NCH-1:0]         gp_set;
    logic [NSIDE-1:0][NCH-1:0]         gp_clr;
    logic [NSIDE-1:0][NCH-1:0]         db_req;      // indexed by requesting side
    logic [NSIDE-1:0][NCH-1:0]         db_pend;
    logic [NSIDE-1:0][NFLAG-1:0]       flags;

    assign s_addr  = {b_addr,  a_addr};
    assign s_we    = {b_we,    a_we};
    assign s_wdata = {b_wdata, a_wdata};
    assign s_re    = {b_re,    a_re};
    assign a_rdata = s_rdata[0];
    assign b_rdata = s_rdata[1];
    assign a_irq   = s_irq[0];
    assign b_irq   = s_irq[1];

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        localparam int O = NSIDE - 1 - s;

        msgu_port u_port (
            .clk       (clk),
            .rst       (rst),
            .addr      (s_addr[s]),
            .we        (s_we[s]),
            .wdata     (s_wdata[s]),
            .re        (s_re[s]),
            .rdata     (s_rdata[s]),
            .irq       (s_irq[s]),
            .tx_wr     (tx_wr[s]),
            .tx_data   (tx_data[s]),
            .tx_busy   (lane_full[s]),
            .rx_full   (lane_full[O]),
            .rx_word   (lane_word[O]),
            .rx_rd     (rx_rd[s]),
            .gp_set    (gp_set[s]),
            .gp_req    (db_req[s]),
            .gp_pend   (db_pend[O]),
            .gp_clr    (gp_clr[s]),
            .flags_out (flags[s]),
            .flags_in  (flags[O])
        );

        for (genvar n = 0; n < NCH; n++) begin : g_chan
            msgu_lane #(.DW(DW)) u_lane (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (tx_wr[s][n]),
                .wr_data (tx_data[s]),
                .rd_en   (rx_rd[O][n]),
                .full    (lane_full[s][n]),
                .word    (lane_word[s][n])
            );

            msgu_doorbell u_bell (
                .clk      (clk),
                .rst      (rst),
                .req_set  (gp_set[s][n]),
                .pend_clr (gp_clr[O][n]),
                .req      (db_req[s][n]),
                .pend     (db_pend[s][n])
            );
        end
    end

endmodule

// File: tb/test_msgu_top.sv
`timescale 1ns/1ps
module test_msgu_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  a_addr, b_addr;
    logic        a_we, b_we, a_re, b_re;
    logic [31:0] a_wdata, b_wdata;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    always #2 clk = ~clk;

    msgu_top i_msgu_top (
        .clk(clk), .rst(rst),
        .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_re(a_re),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_re(b_re),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    localparam logic [5:0] ST = 6'h20;
    localparam logic [5:0] CT = 6'h24;
    localparam logic [31:0] IDLE_ST = 32'h00F0_0000;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] exp_a[$], exp_b[$];
    string       tag_a[$], tag_b[$];
    logic [1:0]  re_d;

    always @(posedge clk) re_d <= {b_re, a_re};

    task automatic judge(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard when registered read data is valid
    always @(negedge clk) begin
        if (re_d[0]) judge(tag_a.pop_front(), a_rdata, exp_a.pop_front());
        if (re_d[1]) judge(tag_b.pop_front(), b_rdata, exp_b.pop_front());
    end

    task automatic wr(int side, logic [5:0] ad, logic [31:0] d);
        if (side == 0) begin a_addr = ad; a_wdata = d; a_we = 1'b1; end
        else           begin b_addr = ad; b_wdata = d; b_we = 1'b1; end
        @(negedge clk);
        a_we = 1'b0; b_we = 1'b0;
    endtask

    task automatic rd(int side, logic [5:0] ad, logic [31:0] exp, string tag);
        if (side == 0) begin exp_a.push_back(exp); tag_a.push_back(tag); a_addr = ad; a_re = 1'b1; end
        else           begin exp_b.push_back(exp); tag_b.push_back(tag); b_addr = ad; b_re = 1'b1; end
        @(negedge clk);
        a_re = 1'b0; b_re = 1'b0;
    endtask

    task automatic pin(string tag, logic act, logic exp);
        judge(tag, {31'd0, act}, {31'd0, exp});
    endtask

    initial begin
        rst = 1'b1;
        a_addr = '0; b_addr = '0; a_we = 0; b_we = 0; a_re = 0; b_re = 0;
        a_wdata = '0; b_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        pin("R1 a_irq", a_irq, 1'b0);
        pin("R1 b_irq", b_irq, 1'b0);
        rd(0, CT, 32'h0, "R1 ctrl A");
        rd(1, CT, 32'h0, "R1 ctrl B");
        rd(0, ST, IDLE_ST, "R1 status A");
        rd(1, ST, IDLE_ST, "R1 status B");

        // R2 / R3 channel 1 A->B
        wr(0, 6'h04, 32'hDEAD_BEEF);
        rd(0, ST, 32'h00B0_0000, "R2 sender empty cleared");
        rd(1, ST, 32'h04F0_0000, "R2 receiver full set");
        rd(1, 6'h14, 32'hDEAD_BEEF, "R2 receive word");
        rd(1, ST, IDLE_ST, "R3 receiver full cleared");
        rd(0, ST, IDLE_ST, "R3 sender empty restored");

        // R4 overwrite before read
        wr(0, 6'h00, 32'h0000_0001);
        wr(0, 6'h00, 32'h0000_0002);
        rd(1, 6'h10, 32'h0000_0002, "R4 newest word");
        rd(1, ST, IDLE_ST, "R4 single read drains");

        // R11 B->A channel 3
        wr(1, 6'h0C, 32'h1234_5678);
        rd(0, ST, 32'h01F0_0000, "R11 A sees full ch3");
        rd(1, ST, 32'h00E0_0000, "R11 B sender empty cleared");
        rd(0, 6'h1C, 32'h1234_5678, "R11 A receive word");
        rd(1, ST, IDLE_ST, "R11 B empty restored");

        // R5 doorbell ch2 A->B
        wr(0, CT, 32'h0002_0000);
        rd(0, CT, 32'h0002_0000, "R5 request visible");
        rd(1, ST, 32'h20F0_0000, "R5 pending at B");
        rd(0, CT, 32'h0, "R5 request self cleared");
        rd(0, ST, IDLE_ST, "R5 A status unaffected");

        // R7 merge, R6 write-zero no effect then W1C
        wr(0, CT, 32'h0002_0000);
        wr(1, ST, 32'h0000_0000);
        rd(1, ST, 32'h20F0_0000, "R6 write zero ignored");
        wr(1, ST, 32'h2000_0000);
        rd(1, ST, IDLE_ST, "R7 one clear removes merged");

        // R8 interrupt masking
        wr(1, CT, 32'h2000_0000);
        pin("R8 b_irq enabled no event", b_irq, 1'b0);
        wr(0, CT, 32'h0002_0000);
        @(negedge clk);
        pin("R8 b_irq doorbell", b_irq, 1'b1);
        wr(1, ST, 32'h2000_0000);
        pin("R8 b_irq cleared", b_irq, 1'b0);
        wr(0, CT, 32'h0080_0000);
        pin("R8 a_irq send empty", a_irq, 1'b1);
        wr(0, 6'h00, 32'h0000_0005);
        pin("R8 a_irq drops on send", a_irq, 1'b0);
        wr(1, CT, 32'h2800_0000);
        pin("R8 b_irq receive full", b_irq, 1'b1);
        rd(1, 6'h10, 32'h0000_0005, "R8 word ch0");
        pin("R8 b_irq drops on read", b_irq, 1'b0);
        pin("R8 a_irq back on empty", a_irq, 1'b1);

        // R9 flags
        wr(0, CT, 32'h0000_0005);
        pin("R9 a_irq off", a_irq, 1'b0);
        rd(1, ST, 32'h00F5_0000, "R9 flags A at B");
        wr(1, ST, 32'h0007_0000);
        rd(1, ST, 32'h00F5_0000, "R9 flags read only");
        wr(1, CT, 32'h0000_0003);
        rd(0, ST, 32'h00F3_0000, "R9 R11 flags B at A");
        rd(0, CT, 32'h0000_0005, "R9 flag readback");

        // R10 reserved reads
        rd(0, 6'h04, 32'h0, "R10 send reg reads zero");
        rd(1, 6'h3C, 32'h0, "R10 unused offset");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule